// File: doc/BRIEF.md
# Wide-to-Narrow Read Data Gearbox

This block lives in the data path of a memory module buffer. Several wide internal read lanes run at half the rate of the single external lane. They deliver their blocks at the same time, and the block merges them into one longer burst on the external lane. Each internal lane beat arrives on a cycle flagged by a slow-rate enable. Each lane keeps a queue of one full block. When every lane in a group holds its complete block, the group is sent out at one beat per clock, lane by lane. The burst carries the request tag that was presented with the group's first beat.

With `SUB_RANKED` set, the four lanes split into two independent groups that serve alternating requests. One group's block can then drain while the other group fills, and the external lane stays busy without a break. Without it, all lanes form a single group. In both supported configurations an external burst is 16 beats long. A lane that receives a beat while its queue is already full drops the beat and sets a sticky error.

Top module: `rd_gearbox`

## Requirements
- R1: After reset, out_valid, out_last and ovf_err are low, and no beat is issued until a group completes.
- R2: A lane stores a beat only in a cycle where slow_en and that lane's in_valid are both high. A lane's data or valid presented while slow_en is low leaves the output stream unchanged.
- R3: A burst is made of the group's lanes in ascending lane index. Each lane's beats go out in arrival order. Every beat of a lower lane is sent before any beat of the next lane. Lane k occupies bits [64k+63:64k] of in_data.
- R4: out_last is high on the final (16th) beat of each burst and on no other beat.
- R5: A group's first output beat is valid in the cycle right after the cycle in which the last missing beat of that group was presented.
- R6: A burst has no idle cycles between its beats. If another group is complete when a burst ends, that group's first beat follows in the next cycle.
- R7: In sub-ranked mode, lanes 0 and 1 form group 0 and lanes 2 and 3 form group 1. When both groups are complete, the group not served last goes first. After reset, group 0 goes first.
- R8: out_tag equals the in_tag presented with the first beat of the group's lowest lane, and stays constant over the whole burst.
- R9: A beat arriving on a lane whose queue holds a full block, with no beat leaving that lane in the same cycle, is dropped. It sets ovf_err, which stays high until reset.
- R10: No beat of a group is issued before every lane of that group holds a complete block, or completes it in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock of the external lane |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_en | input | 1 | Marks cycles carrying an internal lane beat |
| in_valid | input | LANES | Per-lane beat valid |
| in_data | input | LANES*DW | Per-lane beat data, lane k at bits 64k up |
| in_tag | input | TAG_W | Request tag, sampled with a group's first beat |
| out_valid | output | 1 | External beat valid |
| out_data | output | DW | External beat data |
| out_last | output | 1 | Final beat of a burst |
| out_tag | output | TAG_W | Tag of the burst in progress |
| ovf_err | output | 1 | Sticky lane queue overflow |

## Verification
Every output is registered once. The first beat of a group therefore shows at the falling edge right after the rising edge that stores the group's final input beat. The bench checks out_valid low at the falling edge before that rising edge and high at the one after it. The remaining beats follow one per cycle. A monitor compares each beat at a falling edge against a queue of expected beats, last flags and tags. The bench fills that queue ahead of time, in the lane order and group order the requirements give. The overflow flag is due one edge after the ninth beat on a full lane, and the bench samples it at the following falling edge. Absence of gaps is measured by recording the cycle number of every valid beat across a run of back-to-back alternating reads.

// File: rtl/rd_gearbox.sv
module rd_gearbox #(
  parameter int LANES      = 2,
  parameter int DW         = 64,
  parameter int BLK_BEATS  = 8,
  parameter int TAG_W      = 4,
  parameter bit SUB_RANKED = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  slow_en,
  input  logic [LANES-1:0]      in_valid,
  input  logic [LANES*DW-1:0]   in_data,
  input  logic [TAG_W-1:0]      in_tag,
  output logic                  out_valid,
  output logic [DW-1:0]         out_data,
  output logic                  out_last,
  output logic [TAG_W-1:0]      out_tag,
  output logic                  ovf_err
);

  localparam int GROUPS = SUB_RANKED ? 2 : 1;
  localparam int GL     = LANES / GROUPS;
  localparam int BURST  = GL * BLK_BEATS;
  localparam int PW     = $clog2(BLK_BEATS);
  localparam int CW     = $clog2(BLK_BEATS + 1);
  localparam int BW     = $clog2(BURST);
  localparam int LIW    = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [CW-1:0] FULL = CW'(BLK_BEATS);

  logic [DW-1:0]    mem [LANES][BLK_BEATS];
  logic [PW-1:0]    wp [LANES];
  logic [PW-1:0]    rp [LANES];
  logic [CW-1:0]    cnt [LANES];
  logic [TAG_W-1:0] tag_q [2];
  logic [LANES-1:0] full, arrive, wr, pop;
  logic [1:0]       rdy;
  logic             act, grp, last_g, nxt, start, issue, g_cur, burst_end;
  logic [BW-1:0]    bcnt, b_cur;
  logic [LIW-1:0]   lane_cur;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign full[l]   = cnt[l] == FULL;
    assign arrive[l] = slow_en & in_valid[l];
    assign pop[l]    = issue && (lane_cur == LIW'(l));
    assign wr[l]     = arrive[l] & (~full[l] | pop[l]);

    a_r10_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
      pop[l] |-> cnt[l] != '0);
    a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[l] <= FULL);
  end

  always_comb begin
    for (int g = 0; g < 2; g++) begin
      rdy[g] = (g < GROUPS);
      for (int k = 0; k < GL; k++) begin
        if (g < GROUPS) begin
          int idx;
          idx = (g * GL + k) % LANES;
          if (!(full[idx] || (cnt[idx] == FULL - 1'b1 && arrive[idx])))
            rdy[g] = 1'b0;
        end
      end
    end
  end

  assign nxt       = (GROUPS > 1) ? (rdy[~last_g] ? ~last_g : last_g) : 1'b0;
  assign start     = !act && rdy[nxt];
  assign issue     = act || start;
  assign g_cur     = act ? grp : nxt;
  assign b_cur     = act ? bcnt : '0;
  assign burst_end = b_cur == BW'(BURST - 1);

  always_comb lane_cur = LIW'(int'(g_cur) * GL + int'(b_cur >> PW));

  always_ff @(posedge clk)
    for (int l = 0; l < LANES; l++)
      if (wr[l]) mem[l][wp[l]] <= in_data[l*DW +: DW];

  always_ff @(posedge clk)
    for (int l = 0; l < LANES; l++)
      if (!rst_n) begin
        wp[l]  <= '0;
        rp[l]  <= '0;
        cnt[l] <= '0;
      end else begin
        wp[l]  <= wp[l] + PW'(wr[l]);
        rp[l]  <= rp[l] + PW'(pop[l]);
        cnt[l] <= cnt[l] + CW'(wr[l]) - CW'(pop[l]);
      end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act       <= 1'b0;
      grp       <= 1'b0;
      last_g    <= 1'b1;
      bcnt      <= '0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_data  <= '0;
      out_tag   <= '0;
      ovf_err   <= 1'b0;
      tag_q[0]  <= '0;
      tag_q[1]  <= '0;
    end else begin
      out_valid <= issue;
      out_last  <= issue && burst_end;
      if (issue) begin
        out_data <= mem[lane_cur][rp[lane_cur]];
        act      <= !burst_end;
        bcnt     <= burst_end ? '0 : b_cur + 1'b1;
      end
      if (start) begin
        out_tag <= tag_q[nxt];
        grp     <= nxt;
        last_g  <= nxt;
      end
      if (|(arrive & full & ~pop)) ovf_err <= 1'b1;
      for (int g = 0; g < GROUPS; g++)
        if (wr[g*GL] && wp[g*GL] == '0) tag_q[g] <= in_tag;
    end
  end

  a_r4_last_in_beat: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
  a_r6_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_last |=> out_valid);
  a_r8_tag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_last |=> $stable(out_tag));
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);

endmodule

// File: tb/rd_gearbox_test.sv
`timescale 1ns/1ps
module rd_gearbox_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc++;

  logic         ra_n, a_se, a_ov, a_ol, a_err;
  logic [1:0]   a_v;
  logic [127:0] a_d;
  logic [3:0]   a_t, a_ot;
  logic [63:0]  a_od;

  logic         rb_n, b_se, b_ov, b_ol, b_err;
  logic [3:0]   b_v;
  logic [255:0] b_d;
  logic [3:0]   b_t, b_ot;
  logic [63:0]  b_od;

  rd_gearbox #(.LANES(2), .DW(64), .BLK_BEATS(8), .TAG_W(4), .SUB_RANKED(1'b0)) uut (
    .clk(clk), .rst_n(ra_n), .slow_en(a_se), .in_valid(a_v), .in_data(a_d), .in_tag(a_t),
    .out_valid(a_ov), .out_data(a_od), .out_last(a_ol), .out_tag(a_ot), .ovf_err(a_err));

  rd_gearbox #(.LANES(4), .DW(64), .BLK_BEATS(8), .TAG_W(4), .SUB_RANKED(1'b1)) uut_sr (
    .clk(clk), .rst_n(rb_n), .slow_en(b_se), .in_valid(b_v), .in_data(b_d), .in_tag(b_t),
    .out_valid(b_ov), .out_data(b_od), .out_last(b_ol), .out_tag(b_ot), .ovf_err(b_err));

  logic [63:0] ea_d [0:2047];
  logic        ea_l [0:2047];
  logic [3:0]  ea_t [0:2047];
  int ea_w = 0, ea_r = 0;
  logic [63:0] eb_d [0:2047];
  logic        eb_l [0:2047];
  logic [3:0]  eb_t [0:2047];
  int eb_w = 0, eb_r = 0;

  bit trk = 0;
  int prev_c = -1, gaps = 0;
  int sr_last = 1;

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  function automatic bit last_of(int beat);
    return (beat % 16) == 15;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (ra_n && a_ov) begin
      if (ea_r >= ea_w) chk(0, "R10 unexpected beat", a_od, 64'd0);
      else begin
        chk(a_od == ea_d[ea_r], "R2/R3 beat data", a_od, ea_d[ea_r]);
        chk(a_ol == ea_l[ea_r], "R4 last flag", 64'(a_ol), 64'(ea_l[ea_r]));
        chk(a_ot == ea_t[ea_r], "R8 tag", 64'(a_ot), 64'(ea_t[ea_r]));
        ea_r++;
      end
    end
    if (rb_n && b_ov) begin
      if (eb_r >= eb_w) chk(0, "R10 unexpected beat sr", b_od, 64'd0);
      else begin
        chk(b_od == eb_d[eb_r], "R3/R7 beat data sr", b_od, eb_d[eb_r]);
        chk(b_ol == eb_l[eb_r], "R4 last flag sr", 64'(b_ol), 64'(eb_l[eb_r]));
        chk(b_ot == eb_t[eb_r], "R8 tag sr", 64'(b_ot), 64'(eb_t[eb_r]));
        eb_r++;
      end
      if (trk) begin
        if (prev_c >= 0 && cyc != prev_c + 1) gaps++;
        prev_c = cyc;
      end
    end
  end

  task automatic push_a(input logic [63:0] d, input int beat, input logic [3:0] t);
    ea_d[ea_w] = d; ea_l[ea_w] = last_of(beat); ea_t[ea_w] = t; ea_w++;
  endtask

  task automatic push_b(input logic [63:0] d, input int beat, input logic [3:0] t);
    eb_d[eb_w] = d; eb_l[eb_w] = last_of(beat); eb_t[eb_w] = t; eb_w++;
  endtask

  task automatic idle_a();
    a_se = 0;
    a_v  = ($urandom() % 2) ? 2'b11 : 2'b00;
    a_d  = {rnd64(), rnd64()};
    a_t  = 4'($urandom());
  endtask

  task automatic idle_b();
    b_se = 0;
    b_v  = ($urandom() % 2) ? 4'hF : 4'h0;
    b_d  = {rnd64(), rnd64(), rnd64(), rnd64()};
    b_t  = 4'($urandom());
  endtask

  task automatic read_a(input logic [3:0] tag);
    logic [63:0] d [2][8];
    for (int l = 0; l < 2; l++)
      for (int b = 0; b < 8; b++) d[l][b] = rnd64();
    for (int l = 0; l < 2; l++)
      for (int b = 0; b < 8; b++) push_a(d[l][b], l*8 + b, tag);
    for (int b = 0; b < 8; b++) begin
      @(negedge clk);
      if (b == 7) chk(a_ov == 1'b0, "R10 no output before block complete", 64'(a_ov), 64'd0);
      a_se = 1; a_v = 2'b11; a_d = {d[1][b], d[0][b]};
      a_t = (b == 0) ? tag : 4'($urandom());
      @(negedge clk);
      if (b == 7) chk(a_ov == 1'b1, "R5 first beat one cycle after last input", 64'(a_ov), 64'd1);
      idle_a();
    end
    a_v = 0;
  endtask

  task automatic read_b(input int g, input logic [3:0] tag);
    logic [63:0] d [2][8];
    for (int l = 0; l < 2; l++)
      for (int b = 0; b < 8; b++) d[l][b] = rnd64();
    for (int l = 0; l < 2; l++)
      for (int b = 0; b < 8; b++) push_b(d[l][b], l*8 + b, tag);
    sr_last = g;
    for (int b = 0; b < 8; b++) begin
      @(negedge clk);
      b_se = 1; b_v = 4'b0011 << (2*g); b_d = '0;
      b_d[(2*g)*64 +: 64] = d[0][b];
      b_d[(2*g+1)*64 +: 64] = d[1][b];
      b_t = (b == 0) ? tag : 4'($urandom());
      @(negedge clk);
      idle_b();
    end
    b_v = 0;
  endtask

  task automatic read_both(input logic [3:0] tag);
    logic [63:0] d [4][8];
    int f;
    f = 1 - sr_last;
    for (int l = 0; l < 4; l++)
      for (int b = 0; b < 8; b++) d[l][b] = rnd64();
    for (int k = 0; k < 2; k++) begin
      int g;
      g = (k == 0) ? f : 1 - f;
      for (int l = 0; l < 2; l++)
        for (int b = 0; b < 8; b++) push_b(d[2*g + l][b], l*8 + b, tag);
    end
    sr_last = 1 - f;
    for (int b = 0; b < 8; b++) begin
      @(negedge clk);
      b_se = 1; b_v = 4'hF;
      b_d = {d[3][b], d[2][b], d[1][b], d[0][b]};
      b_t = (b == 0) ? tag : 4'($urandom());
      @(negedge clk);
      idle_b();
    end
    b_v = 0;
  endtask

  task automatic drain_b();
    while (eb_r != eb_w) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL R6 watchdog expired actual=%0d expected<%0d", cyc, 150000);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    ra_n = 0; rb_n = 0;
    a_se = 0; a_v = 0; a_d = '0; a_t = 0;
    b_se = 0; b_v = 0; b_d = '0; b_t = 0;
    repeat (3) @(negedge clk);
    ra_n = 1; rb_n = 1;
    @(negedge clk);
    chk(a_ov == 0 && a_ol == 0, "R1 reset outputs", {62'd0, a_ov, a_ol}, 64'd0);
    chk(a_err == 0, "R1 reset error flag", 64'(a_err), 64'd0);
    chk(b_ov == 0 && b_err == 0, "R1 reset outputs sr", {62'd0, b_ov, b_err}, 64'd0);

    read_a(4'h3);
    repeat (18) @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      read_a(4'($urandom()));
      repeat (16 + $urandom() % 5) @(negedge clk);
    end
    chk(ea_r == ea_w, "R3 all beats delivered", 64'(ea_r), 64'(ea_w));

    begin
      logic [63:0] d0 [9];
      logic [63:0] d1 [8];
      for (int b = 0; b < 9; b++) d0[b] = rnd64();
      for (int b = 0; b < 8; b++) d1[b] = rnd64();
      for (int b = 0; b < 8; b++) push_a(d0[b], b, 4'hA);
      for (int b = 0; b < 8; b++) push_a(d1[b], 8 + b, 4'hA);
      for (int b = 0; b < 9; b++) begin
        @(negedge clk);
        if (b == 8) chk(a_err == 0, "R9 no error before overflow", 64'(a_err), 64'd0);
        a_se = 1; a_v = 2'b01; a_d = {64'd0, d0[b]};
        a_t = (b == 0) ? 4'hA : 4'h6;
        @(negedge clk);
        idle_a();
      end
      a_v = 0;
      chk(a_err == 1, "R9 overflow flagged", 64'(a_err), 64'd1);
      repeat (4) @(negedge clk);
      chk(a_ov == 0, "R10 lone full lane issues nothing", 64'(a_ov), 64'd0);
      for (int b = 0; b < 8; b++) begin
        @(negedge clk);
        a_se = 1; a_v = 2'b10; a_d = {d1[b], 64'd0}; a_t = 4'h5;
        @(negedge clk);
        idle_a();
      end
      a_v = 0;
      repeat (20) @(negedge clk);
      chk(a_err == 1, "R9 error sticky", 64'(a_err), 64'd1);
      chk(ea_r == ea_w, "R9 overflow beat dropped", 64'(ea_r), 64'(ea_w));
      ra_n = 0;
      repeat (2) @(negedge clk);
      ra_n = 1;
      @(negedge clk);
      chk(a_err == 0 && a_ov == 0, "R1 reset clears error", {62'd0, a_err, a_ov}, 64'd0);
    end

    read_both(4'h7);
    drain_b();
    read_b(0, 4'h2);
    drain_b();
    read_both(4'h9);
    drain_b();
    chk(eb_r == eb_w, "R7 both groups served in order", 64'(eb_r), 64'(eb_w));

    trk = 1; prev_c = -1; gaps = 0;
    for (int i = 0; i < 12; i++) read_b(i % 2, 4'($urandom()));
    drain_b();
    trk = 0;
    chk(gaps == 0, "R6 alternating reads gapless", 64'(gaps), 64'd0);

    for (int i = 0; i < 8; i++) begin
      read_b(int'($urandom() % 2), 4'($urandom()));
      drain_b();
      repeat ($urandom() % 4) @(negedge clk);
    end
    chk(eb_r == eb_w, "R3 all beats delivered sr", 64'(eb_r), 64'(eb_w));
    chk(b_err == 0, "R9 no overflow in legal traffic", 64'(b_err), 64'd0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule